// File: doc/BRIEF.md
# System Watchdog Timer with Seconds/Minutes Time Base

This block is a countdown watchdog for a system I/O controller. Software writes a start value into a count register, and the counter then steps down on each one-second tick. A configuration bit can switch the unit to minutes, in which case an internal divide-by-sixty prescaler is placed in front of the counter. Accesses on neighbouring peripherals act as keepalive events. These are game-port reads, writes to an infrared receiver's data register, and mouse or keyboard activity. When a source is enabled, its event reloads the counter from the programmed value after a short settle delay.

When the count reaches zero, the block sets a sticky expiry flag. It can also emit a fixed-length pulse on a keyboard-reset request line, a power-good-drop request line, or both. Software can cause the same expiry at once through a force bit. A count of zero means the watchdog is stopped.

The register port is a simple write strobe with a 2-bit register select and an 8-bit data bus. Read data is a combinational view selected by the same 2-bit select. The register select codes are 0 = control, 1 = configuration, 2 = count low byte, 3 = count high byte.

Top module: `sys_watchdog`

## Requirements
- R1: After reset the count is zero and the block is stopped. The control and configuration registers read 0x00 and both request outputs are low.
- R2: A write to the count low byte (select 2) loads the counter with {stored high byte, written low byte} in the same clock edge. Select 2 and select 3 always read the live count, low and high byte. A loaded value of zero leaves the block stopped.
- R3: With configuration bit 7 set (seconds unit), each tick decrements a running counter by one.
- R4: With configuration bit 7 clear (minutes unit), a running counter decrements once every 60 ticks. The tick prescaler restarts from zero on every low-byte load and every keepalive reload.
- R5: A write to the high byte (select 3) does not change the running count. The new value is used only at the next low-byte load or keepalive reload.
- R6: A counter reaching zero by decrement is an expiry, and an expiry sets control bit 0. That bit stays set until a control write with bit 0 equal to 0. A control write with bit 0 equal to 1 leaves it unchanged.
- R7: On each expiry, the keyboard-reset line pulses high for PULSE_LEN clocks if configuration bit 6 is set. The power-good-drop line pulses the same way if configuration bit 4 is set. There is one pulse per expiry, and no further pulses while the counter stays at zero.
- R8: Control bits 7, 6, 5 and 4 enable the keepalive inputs ka_pulse[3] (infrared), ka_pulse[2] (mouse), ka_pulse[1] (keyboard) and ka_pulse[0] (game port). An enabled keepalive seen while the counter is running reloads the counter from the programmed value exactly RELOAD_DELAY clocks later. A disabled source has no effect.
- R9: A control write with bit 1 set forces an immediate expiry and stops the counter. Bit 1 always reads back as 0.
- R10: While the count is zero, ticks and keepalive events leave it at zero.
- R11: Configuration bits 7, 6, 4 and 3:0 (bits 3:0 are an interrupt line select) read back as written, and bit 5 reads 0. Control reads {enables[7:4], 0, 0, 0, expiry flag}.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 control, 1 config, 2 count low, 3 count high |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the selected register |
| sec_tick | input | 1 | One-clock pulse once per second |
| ka_pulse | input | 4 | Keepalive events: [3] infrared, [2] mouse, [1] keyboard, [0] game port |
| kb_reset_o | output | 1 | Keyboard-reset request pulse |
| pwr_good_drop_o | output | 1 | Power-good-drop request pulse |

## Verification
Seconds-unit decrements are exercised with random start values and random tick counts that stay short of expiry. A wrong step size or a missed tick shows up as a count mismatch.

Minutes-unit counting is driven across the 59/60 tick boundary, both before and after a reload. This tells a correct prescaler apart from one that is never cleared or that divides by the wrong amount.

Keepalives use random enable masks against random sources. The count is sampled one clock before and exactly at the reload delay, which separates correct gating from wrong gating and an early reload from a late one.

Expiry is reached both by counting down and by the force bit, under different output-enable settings. The pulse widths and the flag's stickiness are measured on the ports.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_CFG  = 2'd1,
    SEL_CNTL = 2'd2,
    SEL_CNTH = 2'd3
  } wdt_sel_e;

  // configuration bits that hold storage; bit 5 is not implemented
  localparam logic [7:0] CFG_KEEP_MASK = 8'hDF;

  localparam int CFG_UNIT_SEC = 7;
  localparam int CFG_KB_EN    = 6;
  localparam int CFG_PG_EN    = 4;
  localparam int CTRL_FORCE   = 1;
  localparam int CTRL_FLAG    = 0;

  // true when the prescaler sits on its final count
  function automatic logic presc_last(input int pre, input int div);
    return pre == div - 1;
  endfunction

  // control register read view
  function automatic logic [7:0] ctrl_view(input logic [3:0] en, input logic flag);
    return {en, 3'b000, flag};
  endfunction

endpackage

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       sel,
  input  logic [7:0]       wdata,
  input  logic             expire_evt,
  input  logic [CNT_W-1:0] cur_count,
  output logic [3:0]       ka_en,
  output logic             unit_sec,
  output logic             kb_en,
  output logic             pg_en,
  output logic [CNT_W-1:0] preset,
  output logic [CNT_W-1:0] load_val,
  output logic             lo_load,
  output logic             force_evt,
  output logic [7:0]       rdata
);

  logic [3:0] en_q;
  logic [7:0] cfg_q;
  logic [7:0] lo_q;
  logic       flag_q;
  logic       ctrl_wr;
  logic       flag_clr;

  assign ctrl_wr   = wr_en && (sel == SEL_CTRL);
  assign lo_load   = wr_en && (sel == SEL_CNTL);
  assign force_evt = ctrl_wr && wdata[CTRL_FORCE];
  assign flag_clr  = ctrl_wr && !wdata[CTRL_FLAG];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= '0;
      cfg_q  <= '0;
      lo_q   <= '0;
      flag_q <= 1'b0;
    end else begin
      if (ctrl_wr) en_q <= wdata[7:4];
      if (wr_en && sel == SEL_CFG) cfg_q <= wdata & CFG_KEEP_MASK;
      if (lo_load) lo_q <= wdata;
      if (expire_evt) flag_q <= 1'b1;
      else if (flag_clr) flag_q <= 1'b0;
    end
  end

  generate
    if (CNT_W > 8) begin : g_hi
      logic [CNT_W-9:0] hi_q;
      always_ff @(posedge clk) begin
        if (!rst_n) hi_q <= '0;
        else if (wr_en && sel == SEL_CNTH) hi_q <= wdata[CNT_W-9:0];
      end
      assign preset   = {hi_q, lo_q};
      assign load_val = {hi_q, wdata};
    end else begin : g_lo
      assign preset   = lo_q;
      assign load_val = wdata;
    end
  endgenerate

  assign ka_en    = en_q;
  assign unit_sec = cfg_q[CFG_UNIT_SEC];
  assign kb_en    = cfg_q[CFG_KB_EN];
  assign pg_en    = cfg_q[CFG_PG_EN];

  always_comb begin
    case (wdt_sel_e'(sel))
      SEL_CTRL: rdata = ctrl_view(en_q, flag_q);
      SEL_CFG:  rdata = cfg_q;
      SEL_CNTL: rdata = cur_count[7:0];
      default:  rdata = 8'(cur_count >> 8);
    endcase
  end

  p_flag_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    flag_q && !flag_clr |=> flag_q);
  p_flag_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    expire_evt |=> flag_q);

endmodule

// File: rtl/wdt_timebase.sv
module wdt_timebase
  import wdt_pkg::*;
#(
  parameter int MIN_DIV = 60
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sec_tick,
  input  logic unit_sec,
  input  logic running,
  input  logic clr_pre,
  output logic dec_strobe
);

  localparam int PW = $clog2(MIN_DIV);

  logic [PW-1:0] pre_q;
  logic          wrap;

  assign wrap       = presc_last(int'(pre_q), MIN_DIV);
  assign dec_strobe = sec_tick && running && (unit_sec || wrap);

  always_ff @(posedge clk) begin
    if (!rst_n) pre_q <= '0;
    else if (clr_pre) pre_q <= '0;
    else if (sec_tick && running && !unit_sec)
      pre_q <= wrap ? '0 : pre_q + 1'b1;
  end

  p_pre_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    int'(pre_q) < MIN_DIV);
  p_pre_cleared_r4: assert property (@(posedge clk) disable iff (!rst_n)
    clr_pre |=> pre_q == '0);

endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int CNT_W        = 16,
  parameter int RELOAD_DELAY = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lo_load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             force_evt,
  input  logic [CNT_W-1:0] preset,
  input  logic             ka_hit,
  input  logic             dec_strobe,
  output logic [CNT_W-1:0] cur_count,
  output logic             running,
  output logic             expire_evt,
  output logic             reload_fire,
  output logic             clr_pre
);

  localparam int DW = $clog2(RELOAD_DELAY + 1);

  logic [CNT_W-1:0] cur_q;
  logic             pend_q;
  logic [DW-1:0]    dly_q;
  logic             count_ends;

  assign running     = cur_q != '0;
  assign reload_fire = pend_q && (dly_q == '0);
  assign count_ends  = dec_strobe && (cur_q == CNT_W'(1));
  assign expire_evt  = force_evt || (!lo_load && !reload_fire && count_ends);
  assign clr_pre     = lo_load || reload_fire || !running;
  assign cur_count   = cur_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_q <= '0;
    end else if (lo_load) begin
      cur_q <= load_val;
    end else if (force_evt) begin
      cur_q <= '0;
    end else if (reload_fire) begin
      cur_q <= preset;
    end else if (dec_strobe && running) begin
      cur_q <= cur_q - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      dly_q  <= '0;
    end else if (lo_load || force_evt || expire_evt || reload_fire) begin
      pend_q <= 1'b0;
      dly_q  <= '0;
    end else if (ka_hit && running && !pend_q) begin
      pend_q <= 1'b1;
      dly_q  <= DW'(RELOAD_DELAY - 1);
    end else if (pend_q) begin
      dly_q  <= dly_q - 1'b1;
    end
  end

  p_dec_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    running && dec_strobe && !lo_load && !force_evt && !reload_fire
      |=> cur_q == $past(cur_q) - 1'b1);
  p_reload_value_r8: assert property (@(posedge clk) disable iff (!rst_n)
    reload_fire && !lo_load && !force_evt |=> cur_q == $past(preset));
  p_force_stop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    force_evt |=> cur_q == '0);
  p_stopped_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !running && !lo_load |=> cur_q == '0);

endmodule

// File: rtl/wdt_pulse.sv
module wdt_pulse #(
  parameter int PULSE_LEN = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  input  logic en,
  output logic pulse_o
);

  localparam int LW = $clog2(PULSE_LEN + 1);

  logic [LW-1:0] left_q;

  always_ff @(posedge clk) begin
    if (!rst_n) left_q <= '0;
    else if (fire && en) left_q <= LW'(PULSE_LEN);
    else if (left_q != '0) left_q <= left_q - 1'b1;
  end

  assign pulse_o = left_q != '0;

  p_pulse_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fire && en |=> pulse_o);
  p_pulse_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pulse_o) |-> $past(fire && en));

endmodule

// File: rtl/sys_watchdog.sv
module sys_watchdog #(
  parameter int CNT_W        = 16,
  parameter int RELOAD_DELAY = 4,
  parameter int PULSE_LEN    = 3,
  parameter int MIN_DIV      = 60
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_wr,
  input  logic [1:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       sec_tick,
  input  logic [3:0] ka_pulse,
  output logic       kb_reset_o,
  output logic       pwr_good_drop_o
);

  localparam int NOUT = 2;

  logic [3:0]       ka_en;
  logic             unit_sec, kb_en, pg_en;
  logic [CNT_W-1:0] preset, load_val, cur_count;
  logic             lo_load, force_evt;
  logic             running, expire_evt, reload_fire, clr_pre;
  logic             dec_strobe;
  logic             ka_hit;
  logic [NOUT-1:0]  out_en, out_pulse;

  assign ka_hit = |(ka_pulse & ka_en);

  wdt_regs #(.CNT_W(CNT_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (reg_wr),
    .sel        (reg_addr),
    .wdata      (reg_wdata),
    .expire_evt (expire_evt),
    .cur_count  (cur_count),
    .ka_en      (ka_en),
    .unit_sec   (unit_sec),
    .kb_en      (kb_en),
    .pg_en      (pg_en),
    .preset     (preset),
    .load_val   (load_val),
    .lo_load    (lo_load),
    .force_evt  (force_evt),
    .rdata      (reg_rdata)
  );

  wdt_timebase #(.MIN_DIV(MIN_DIV)) u_tb (
    .clk        (clk),
    .rst_n      (rst_n),
    .sec_tick   (sec_tick),
    .unit_sec   (unit_sec),
    .running    (running),
    .clr_pre    (clr_pre),
    .dec_strobe (dec_strobe)
  );

  wdt_counter #(.CNT_W(CNT_W), .RELOAD_DELAY(RELOAD_DELAY)) u_cnt (
    .clk         (clk),
    .rst_n       (rst_n),
    .lo_load     (lo_load),
    .load_val    (load_val),
    .force_evt   (force_evt),
    .preset      (preset),
    .ka_hit      (ka_hit),
    .dec_strobe  (dec_strobe),
    .cur_count   (cur_count),
    .running     (running),
    .expire_evt  (expire_evt),
    .reload_fire (reload_fire),
    .clr_pre     (clr_pre)
  );

  assign out_en = {pg_en, kb_en};

  generate
    for (genvar g = 0; g < NOUT; g++) begin : g_out
      wdt_pulse #(.PULSE_LEN(PULSE_LEN)) u_pulse (
        .clk     (clk),
        .rst_n   (rst_n),
        .fire    (expire_evt),
        .en      (out_en[g]),
        .pulse_o (out_pulse[g])
      );
    end
  endgenerate

  assign kb_reset_o      = out_pulse[0];
  assign pwr_good_drop_o = out_pulse[1];

  p_no_ka_reload_when_stopped_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> !reload_fire);

endmodule

// File: tb/sys_watchdog_test.sv
module sys_watchdog_test;

  localparam int CLK_PERIOD = 10;
  localparam int DLY  = 4;
  localparam int PLEN = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] reg_rdata;
  logic       sec_tick = 1'b0;
  logic [3:0] ka_pulse = 4'd0;
  logic       kb, pg;

  int n_tests = 0;
  int n_fail  = 0;
  int kb_cycles = 0;
  int pg_cycles = 0;

  sys_watchdog #(.CNT_W(16), .RELOAD_DELAY(DLY), .PULSE_LEN(PLEN), .MIN_DIV(60)) uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sec_tick(sec_tick),
    .ka_pulse(ka_pulse), .kb_reset_o(kb), .pwr_good_drop_o(pg)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    if (kb) kb_cycles++;
    if (pg) pg_cycles++;
  end

  function automatic int exp_sec(input int v, input int n);
    return (n >= v) ? 0 : v - n;
  endfunction

  function automatic int exp_min(input int v, input int n);
    return (n / 60 >= v) ? 0 : v - n / 60;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(posedge clk); #1;
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output int d);
    reg_addr = a;
    #1;
    d = int'(reg_rdata);
  endtask

  task automatic rd_count(output int c);
    int lo, hi;
    rd(2'd2, lo);
    rd(2'd3, hi);
    c = hi * 256 + lo;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); sec_tick = 1'b1;
      @(posedge clk); #1; sec_tick = 1'b0;
    end
  endtask

  task automatic ka(input int idx);
    @(negedge clk); ka_pulse[idx] = 1'b1;
    @(posedge clk); #1; ka_pulse = 4'd0;
  endtask

  task automatic load(input int v);
    wr(2'd3, 8'(v >> 8));
    wr(2'd2, 8'(v));
  endtask

  task automatic wait_cycles(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_tests++; n_fail++;
    $display("FAIL watchdog (all requirements): actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int c, r, v, n, en, src;
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;

    // R1 reset state
    rd(2'd0, r); check("R1 ctrl", r, 0);
    rd(2'd1, r); check("R1 cfg", r, 0);
    rd_count(c); check("R1 count", c, 0);
    check("R1 kb line", int'(kb), 0);
    check("R1 pg line", int'(pg), 0);

    // R11 readback
    wr(2'd1, 8'hFF); rd(2'd1, r); check("R11 cfg mask", r, 8'hDF);
    wr(2'd0, 8'hF0); rd(2'd0, r); check("R11 ctrl view", r, 8'hF0);
    wr(2'd0, 8'h00);

    // R2 load and zero
    wr(2'd1, 8'h80);
    wr(2'd3, 8'h12); wr(2'd2, 8'h34);
    rd_count(c); check("R2 load 16-bit", c, 16'h1234);
    load(0); rd_count(c); check("R2 zero load stops", c, 0);
    ticks(3); rd_count(c); check("R10 ticks while stopped", c, 0);

    // R3 random seconds countdown
    for (int i = 0; i < 12; i++) begin
      v = 1 + int'($urandom % 40);
      n = int'($urandom % v);
      load(v); ticks(n);
      rd_count(c); check("R3 seconds countdown", c, exp_sec(v, n));
    end

    // R5 high byte deferred, R8 reload delay
    load(10); ticks(3);
    wr(2'd3, 8'h01);
    rd_count(c); check("R5 high write deferred", c, 7);
    wr(2'd0, 8'h10);
    ka(0);
    wait_cycles(DLY - 1);
    rd_count(c); check("R8 no reload before delay", c, 7);
    wait_cycles(1);
    rd_count(c); check("R8 reload at delay", c, 16'h010A);
    ka(3);
    wait_cycles(DLY + 2);
    rd_count(c); check("R8 disabled source ignored", c, 16'h010A);

    // R8 random enable/source pairs
    for (int i = 0; i < 8; i++) begin
      en  = int'($urandom % 16);
      src = int'($urandom % 4);
      wr(2'd0, 8'(en << 4));
      load(16'h0120);
      ticks(1);
      ka(src);
      wait_cycles(DLY);
      rd_count(c);
      check("R8 source gating", c, en[src] ? 16'h0120 : 16'h011F);
    end
    wr(2'd0, 8'h00);

    // R4 minutes unit and prescaler restart
    wr(2'd1, 8'h00);
    load(5);
    ticks(59); rd_count(c); check("R4 59 ticks no step", c, 5);
    ticks(1);  rd_count(c); check("R4 60th tick steps", c, 4);
    ticks(30); load(5);
    ticks(59); rd_count(c); check("R4 prescaler cleared by load", c, 5);
    ticks(1);  rd_count(c); check("R4 step after restart", c, 4);
    n = int'($urandom % 170);
    load(3); ticks(n);
    rd_count(c); check("R4 random minutes", c, exp_min(3, n));

    // R6 / R7 expiry with both lines
    wr(2'd1, 8'hD3);
    wr(2'd0, 8'h00);
    load(2);
    kb_cycles = 0; pg_cycles = 0;
    ticks(2);
    rd_count(c); check("R6 count at zero", c, 0);
    rd(2'd0, r); check("R6 flag set", r, 8'h01);
    wait_cycles(PLEN + 3);
    check("R7 kb pulse length", kb_cycles, PLEN);
    check("R7 pg pulse length", pg_cycles, PLEN);
    ticks(3); wait_cycles(PLEN + 1);
    check("R7 single pulse per expiry", kb_cycles, PLEN);
    wr(2'd0, 8'h01); rd(2'd0, r); check("R6 write one keeps flag", r, 8'h01);
    wr(2'd0, 8'h00); rd(2'd0, r); check("R6 write zero clears flag", r, 0);

    // R7 keyboard only, then neither
    wr(2'd1, 8'hC0);
    load(1); kb_cycles = 0; pg_cycles = 0;
    ticks(1); wait_cycles(PLEN + 2);
    check("R7 kb only kb", kb_cycles, PLEN);
    check("R7 kb only pg", pg_cycles, 0);
    wr(2'd1, 8'h80); wr(2'd0, 8'h00);
    load(1); kb_cycles = 0; pg_cycles = 0;
    ticks(1); wait_cycles(PLEN + 2);
    check("R7 none enabled", kb_cycles + pg_cycles, 0);
    rd(2'd0, r); check("R6 flag without lines", r, 8'h01);

    // R9 force
    wr(2'd1, 8'h90); wr(2'd0, 8'h00);
    load(50); kb_cycles = 0; pg_cycles = 0;
    wr(2'd0, 8'h12);
    rd_count(c); check("R9 force stops count", c, 0);
    rd(2'd0, r); check("R9 force bit reads zero", r, 8'h11);
    wait_cycles(PLEN + 2);
    check("R9 force pg pulse", pg_cycles, PLEN);
    check("R9 force kb masked", kb_cycles, 0);

    // R10 keepalive while stopped
    ka(0); wait_cycles(DLY + 2); ticks(2);
    rd_count(c); check("R10 keepalive while stopped", c, 0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule